// File: doc/BRIEF.md
# Switchable-Latency Read Output Stage

This block is the read-data output stage of a small synchronous burst SRAM with a 32-bit word. The memory array hands it one read word per cycle. The block decides, cycle by cycle, whether that word is placed on the shared data bus and when. The bus is modelled as a data vector plus a driver-enable flag. A low driver enable means the bus is at high impedance.

A static latency-select input picks between two paths. In the flow-through path the array word goes straight to the bus during the cycle after the command edge, which gives 2-1-1-1 burst beats. In the registered path the word is first loaded into an output register on the next rising edge, which gives 3-1-1-1 beats. A deselect is pushed through the same pipeline depth as a read, so the bus stays driven for one full cycle after the deselect edge and is released just after the following edge. A write frees the bus at once. An asynchronous output-enable and an asynchronous sleep input gate the drivers without waiting for the clock. Sleep also freezes every register so that no held state is lost.

The block is built around a four-state bus FSM:
- `ST_OFF`: the bus is released.
- `ST_LIVE`: the bus shows the array word directly.
- `ST_REG`: the bus shows the output register.
- `ST_HOLD`: the deselect grace cycle in flow-through mode, showing the output register.

The named transitions are:
- read-start: OFF/HOLD to LIVE (flow-through).
- land: any state to REG when a registered read is pending.
- grace: LIVE/REG to HOLD on a flow-through deselect.
- release: HOLD/REG to OFF.
- write-cut: any state to OFF.

A command register remembers the last operation kind (read, write, deselect). Cycles with no strobe continue a burst of that kind.

Top module: `rdo_stage`

## Requirements
- R1: While `rst_n` is low, and after it until the first command, `bus_oe` is 0 and `bus_dout` is 0.
- R2: A strobed cycle selects the device only when `en0_n`=0, `en1`=1 and `en2_n`=0 on the rising edge. A strobe with any of the three inactive is a deselect, whatever `wr_req` is.
- R3: With `lat_sel`=0 (flow-through), a selected read at edge k makes `bus_oe`=1 during the following cycle, with `bus_dout` following `arr_rdata` combinationally.
- R4: With `lat_sel`=1 (registered), the `arr_rdata` present in the cycle after read edge k is loaded at edge k+1 and driven until edge k+2. Later changes of `arr_rdata` do not reach `bus_dout`. The bus is not driven by this read during the cycle after edge k.
- R5: A cycle with `adr_strobe`=0 repeats the previous operation kind. A read burst therefore delivers one new word per cycle after its first one.
- R6: A deselect at edge k keeps the bus driven for the cycle after k and releases it after edge k+1. In flow-through mode the held word is the `arr_rdata` present at edge k. In registered mode it is the last pending read word.
- R7: A write (selected strobe with `wr_req`=1) releases the bus right after its edge in both modes, even with a registered read pending.
- R8: `oe_n`=1 forces `bus_oe` to 0 at once, with no clock edge. Returning it to 0 restores the driven state.
- R9: `sleep`=1 forces `bus_oe` to 0 at once and freezes all internal state. After `sleep` returns to 0, the bus resumes with the same state and held word.

Bus state encoding: `bus_oe`=1 means the data bus is driven with `bus_dout`; `bus_oe`=0 means the bus is at high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| lat_sel | input | 1 | 1 = registered path, 0 = flow-through |
| adr_strobe | input | 1 | New command this cycle |
| en0_n | input | 1 | Chip enable, active low |
| en1 | input | 1 | Chip enable, active high |
| en2_n | input | 1 | Chip enable, active low |
| wr_req | input | 1 | Strobed command is a write |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous low-power request |
| arr_rdata | input | DATA_W | Word from the memory array |
| bus_dout | output | DATA_W | Data presented to the bus drivers |
| bus_oe | output | 1 | Bus driver enable |

## Verification
The bench targets the exact cycle on which the bus releases after a deselect. A single-cycle-deselect design would drop the bus one cycle early, and a missing grace word would show live array data instead of the held word. In registered mode it changes the array word after the load edge to expose a design that leaks the flow-through path into the register path. It places a write directly behind a pending registered read, where a wrong priority would drive read data onto a bus meant for input. It also raises sleep and output-enable between edges, where a synchronous implementation would lag a cycle and a design that lost state in sleep would return with the wrong word.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
    typedef enum logic [1:0] {
        K_DESEL = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2
    } op_kind_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LIVE = 2'd1,
        ST_REG  = 2'd2,
        ST_HOLD = 2'd3
    } bus_st_t;
endpackage

// File: rtl/rdo_cmd_decode.sv
module rdo_cmd_decode
    import rdo_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sleep,
    input  logic     adr_strobe,
    input  logic     en0_n,
    input  logic     en1,
    input  logic     en2_n,
    input  logic     wr_req,
    output op_kind_t eff_op
);
    op_kind_t kind_q;
    logic     chip_sel;

    assign chip_sel = !en0_n && en1 && !en2_n;

    // a strobe loads a new kind; an idle strobe continues the burst
    always_comb begin
        if (adr_strobe)
            eff_op = chip_sel ? (wr_req ? K_WRITE : K_READ) : K_DESEL;
        else
            eff_op = kind_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            kind_q <= K_DESEL;
        else if (!sleep)
            kind_q <= eff_op;
    end

    // R2: one inactive enable on a strobe gives a deselect
    a_r2_enable_desel: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_strobe && !sleep && (!en1 || en0_n || en2_n)) |=> (kind_q == K_DESEL));
endmodule

// File: rtl/rdo_bus_fsm.sv
module rdo_bus_fsm
    import rdo_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sleep,
    input  logic     lat_sel,
    input  op_kind_t eff_op,
    output bus_st_t  state_q,
    output logic     capture
);
    bus_st_t state_d;
    logic    pend_q;
    logic    pend_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            pend_q  <= 1'b0;
        end else if (!sleep) begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // next state
    always_comb begin
        pend_d  = lat_sel && (eff_op == K_READ);
        state_d = ST_OFF;
        if (eff_op == K_WRITE) begin
            state_d = ST_OFF;                         // write-cut
        end else if (lat_sel) begin
            state_d = pend_q ? ST_REG : ST_OFF;       // land / release
        end else begin
            unique case (state_q)
                ST_OFF, ST_HOLD:
                    state_d = (eff_op == K_READ) ? ST_LIVE : ST_OFF;
                ST_LIVE, ST_REG:
                    state_d = (eff_op == K_READ) ? ST_LIVE : ST_HOLD;   // grace
                default:
                    state_d = ST_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        capture = 1'b0;
        if (!sleep)
            capture = lat_sel ? pend_q : (state_q == ST_LIVE);
    end

    // R7: a write always frees the bus next cycle
    a_r7_write_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_op == K_WRITE && !sleep) |=> (state_q == ST_OFF));
    // R4: a pending registered read lands
    a_r4_pipe_land: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_sel && pend_q && !sleep && eff_op != K_WRITE) |=> (state_q == ST_REG));
    // R3: flow-through read drives live data next cycle
    a_r3_flow_live: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_sel && eff_op == K_READ && !sleep) |=> (state_q == ST_LIVE));
    // R6: flow-through deselect keeps one grace cycle
    a_r6_grace: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_sel && state_q == ST_LIVE && eff_op == K_DESEL && !sleep) |=> (state_q == ST_HOLD));
    // R9: sleep freezes the state
    a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(state_q));
endmodule

// File: rtl/rdo_datapath.sv
module rdo_datapath
    import rdo_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              oe_n,
    input  logic              capture,
    input  bus_st_t           state_q,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe
);
    logic [DATA_W-1:0] out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= '0;
        else if (capture)
            out_q <= arr_rdata;
    end

    assign bus_dout = (state_q == ST_LIVE) ? arr_rdata : out_q;
    assign bus_oe   = (state_q != ST_OFF) && !oe_n && !sleep;

    // R9: the held word survives sleep
    a_r9_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(out_q));
endmodule

// File: rtl/rdo_stage.sv
module rdo_stage
    import rdo_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_sel,
    input  logic              adr_strobe,
    input  logic              en0_n,
    input  logic              en1,
    input  logic              en2_n,
    input  logic              wr_req,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe
);
    op_kind_t eff_op;
    bus_st_t  state_q;
    logic     capture;

    rdo_cmd_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep      (sleep),
        .adr_strobe (adr_strobe),
        .en0_n      (en0_n),
        .en1        (en1),
        .en2_n      (en2_n),
        .wr_req     (wr_req),
        .eff_op     (eff_op)
    );

    rdo_bus_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep   (sleep),
        .lat_sel (lat_sel),
        .eff_op  (eff_op),
        .state_q (state_q),
        .capture (capture)
    );

    rdo_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .oe_n      (oe_n),
        .capture   (capture),
        .state_q   (state_q),
        .arr_rdata (arr_rdata),
        .bus_dout  (bus_dout),
        .bus_oe    (bus_oe)
    );

    // R1: bus released while in reset
    a_r1_reset_off: assert property (@(posedge clk) !rst_n |-> !bus_oe);
endmodule

// File: tb/sim_rdo_stage.sv
module sim_rdo_stage;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lat_sel = 1'b0;
    logic         adr_strobe = 1'b0;
    logic         en0_n = 1'b1;
    logic         en1 = 1'b0;
    logic         en2_n = 1'b1;
    logic         wr_req = 1'b0;
    logic         oe_n = 1'b0;
    logic         sleep = 1'b0;
    logic [W-1:0] arr_rdata = '0;
    logic [W-1:0] bus_dout;
    logic         bus_oe;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    rdo_stage #(.DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .lat_sel(lat_sel), .adr_strobe(adr_strobe),
        .en0_n(en0_n), .en1(en1), .en2_n(en2_n), .wr_req(wr_req),
        .oe_n(oe_n), .sleep(sleep), .arr_rdata(arr_rdata),
        .bus_dout(bus_dout), .bus_oe(bus_oe)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic cmd(input logic stb, input logic e0n, input logic e1, input logic e2n, input logic wr);
        adr_strobe = stb; en0_n = e0n; en1 = e1; en2_n = e2n; wr_req = wr;
    endtask

    task automatic rd();   cmd(1, 0, 1, 0, 0); endtask
    task automatic wrc();  cmd(1, 0, 1, 0, 1); endtask
    task automatic des();  cmd(1, 0, 0, 0, 0); endtask
    task automatic cont(); adr_strobe = 0; endtask

    task automatic settle();
        des(); tick(); tick(); tick();
    endtask

    task automatic t_reset();
        #3;
        chk("R1 oe in reset", W'(bus_oe), 0);
        chk("R1 data in reset", bus_dout, 0);
        tick();
        rst_n = 1'b1;
        tick();
        chk("R1 oe after reset", W'(bus_oe), 0);
    endtask

    task automatic t_enables();
        lat_sel = 0;
        cmd(1, 1, 1, 0, 0); tick();
        chk("R2 en0_n high deselects", W'(bus_oe), 0);
        cmd(1, 0, 0, 0, 0); tick();
        chk("R2 en1 low deselects", W'(bus_oe), 0);
        cmd(1, 0, 1, 1, 1); tick();
        chk("R2 en2_n high deselects write", W'(bus_oe), 0);
        rd(); arr_rdata = 32'h1111_0001; tick();
        chk("R2 all enabled selects", W'(bus_oe), 1);
        settle();
    endtask

    task automatic t_flow();
        lat_sel = 0;
        rd(); arr_rdata = 32'hA000_0001; tick();
        chk("R3 flow oe", W'(bus_oe), 1);
        chk("R3 flow data", bus_dout, 32'hA000_0001);
        arr_rdata = 32'hA000_0002; #1;
        chk("R3 flow live follow", bus_dout, 32'hA000_0002);
        cont(); tick();
        chk("R5 flow burst beat", W'(bus_oe), 1);
        arr_rdata = 32'hC000_0001;
        des(); tick();
        arr_rdata = 32'hD000_0001; #1;
        chk("R6 flow grace oe", W'(bus_oe), 1);
        chk("R6 flow held word", bus_dout, 32'hC000_0001);
        cont(); tick();
        chk("R6 flow release", W'(bus_oe), 0);
        settle();
    endtask

    task automatic t_pipe();
        lat_sel = 1;
        rd(); arr_rdata = 32'hEEEE_EEEE; tick();
        chk("R4 pipe first cycle undriven", W'(bus_oe), 0);
        arr_rdata = 32'hB000_0001; cont(); tick();
        chk("R4 pipe oe", W'(bus_oe), 1);
        chk("R4 pipe data", bus_dout, 32'hB000_0001);
        arr_rdata = 32'hB000_0002; #1;
        chk("R4 pipe registered", bus_dout, 32'hB000_0001);
        tick();
        chk("R5 pipe burst beat", bus_dout, 32'hB000_0002);
        arr_rdata = 32'hB000_0003;
        des(); tick();
        chk("R6 pipe grace oe", W'(bus_oe), 1);
        chk("R6 pipe last word", bus_dout, 32'hB000_0003);
        cont(); tick();
        chk("R6 pipe release", W'(bus_oe), 0);
        settle();
    endtask

    task automatic t_write();
        lat_sel = 1;
        rd(); tick();
        cont(); arr_rdata = 32'h5555_0001; tick();
        chk("R7 pipe driving before write", W'(bus_oe), 1);
        wrc(); tick();
        chk("R7 pipe write cut", W'(bus_oe), 0);
        settle();
        lat_sel = 1;
        rd(); tick();
        wrc(); tick();
        chk("R7 write over pending read", W'(bus_oe), 0);
        settle();
        lat_sel = 0;
        rd(); tick();
        wrc(); tick();
        chk("R7 flow write cut", W'(bus_oe), 0);
        settle();
    endtask

    task automatic t_oe();
        lat_sel = 0;
        rd(); arr_rdata = 32'h0E0E_0001; tick();
        cont();
        oe_n = 1; #1;
        chk("R8 oe_n high releases", W'(bus_oe), 0);
        oe_n = 0; #1;
        chk("R8 oe_n low restores", W'(bus_oe), 1);
        settle();
    endtask

    task automatic t_sleep();
        lat_sel = 1;
        rd(); arr_rdata = 32'h5100_0000; tick();
        cont(); arr_rdata = 32'h5100_0001; tick();
        chk("R9 driving before sleep", bus_dout, 32'h5100_0001);
        sleep = 1; #1;
        chk("R9 sleep releases", W'(bus_oe), 0);
        arr_rdata = 32'h5100_0002; des(); tick(); tick();
        sleep = 0; #1;
        chk("R9 wake oe", W'(bus_oe), 1);
        chk("R9 wake word kept", bus_dout, 32'h5100_0001);
        settle();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_enables();
        t_flow();
        t_pipe();
        t_write();
        t_oe();
        t_sleep();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule